// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block is the host-facing slave of a programmable filter. An 8-bit processor bus with a 2-bit address reaches a configuration register, a result-normalization register, a filter-length register and a write-only coefficient port. The bus can work in either of two styles. In strobe/direction style, one active-low data strobe qualifies the access and a direction level picks read or write. In split-strobe style, there are separate active-low write and read strobes. A configuration bit selects the style. A lock bit makes the choice permanent until the next reset. Before the lock is set, the port always decodes the bus in strobe/direction style and only the configuration register can be written.

Coefficients arrive as pairs of bytes at address 0. A configuration bit sets which byte comes first. Each completed pair is sent out on a one-cycle core write port at ascending indices. After the final coefficient, the block writes zeros to the rest of the last group of four. Configuration reads carry load-progress flags.

A four-state machine sequences every access. ST_IDLE waits for the start of an access. ST_IDLE goes to ST_WR_HOLD on a write and to ST_RD_HOLD on a read. When a write completes the last coefficient of an unaligned length, ST_IDLE goes to ST_PAD instead. ST_PAD emits one zero write per cycle and goes to ST_WR_HOLD after the write whose index has low bits 11. ST_WR_HOLD and ST_RD_HOLD return to ST_IDLE once the access has ended.

Top module: `host_reg_port`

## Requirements
- R1: After reset, a configuration read (address 1) returns 0xA2 while buf_full is 1. Reads of address 2 and address 3 return 0, and run_en and seq_mode are 0.
- R2: In strobe/direction style, an access is active while cs_n=0 and bus_strb_n=0. A bus_rw value of 1 means read and 0 means write. Read data appears on bus_rdata one clock after the access begins, stays while the access lasts, and is 0 one clock after the access ends.
- R3: While unlocked (configuration bit 3 = 0), writes to addresses 0, 2 and 3 have no effect: no coefficient write occurs and those registers read 0 afterwards.
- R4: With configuration bits 1 and 3 both set, the split-strobe style is used. bus_strb_n is the active-low write strobe and bus_rw is the active-low read strobe, both qualified by cs_n=0.
- R5: Once bit 3 is set, it cannot be cleared by a write, and bit 1 no longer changes. Bits 0 and 2 stay writable.
- R6: Configuration read layout, from bit 7 down to bit 0:
  - bit 7: the load index equals the order register.
  - bit 6: the order is at least 4 and the load index lies in the same group of four as the order.
  - bit 5: the buf_full pin.
  - bit 4: the order is at least 4 (this bit also drives seq_mode).
  - bits 3..0: the stored bits.
  Bits 7..4 ignore writes.
- R7: The normalization register (address 2, 5 bits, upper read bits 0) and the order register (address 3, 8 bits, taps minus one) read back what was written and drive norm_sel and order_m1. Writing the order also restarts the load index and the byte pairing.
- R8: Two byte writes to address 0 form one 16-bit coefficient. With bit 2 = 1 the first byte is the upper byte; with bit 2 = 0 it is the lower byte. coef_we pulses for one clock, one clock after the second byte's access begins, at indices 0, 1, 2 and so on.
- R9: After the coefficient whose index equals the order, if the order's low two bits are not 11, zero data is written on consecutive clocks to each index from order+1 up to the next index with low bits 11. The load index then wraps to 0.
- R10: Reads of address 0 return 0.
- R11: run_en equals configuration bit 0 only while bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the lock |
| cs_n | input | 1 | Active-low chip select |
| bus_addr | input | 2 | Register address |
| bus_strb_n | input | 1 | Data strobe, or write strobe in split style |
| bus_rw | input | 1 | Direction level, or read strobe in split style |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 outside reads |
| buf_full | input | 1 | Sample buffer full flag from the core |
| run_en | output | 1 | Filtering enabled |
| seq_mode | output | 1 | More than one group of four taps |
| norm_sel | output | 5 | Normalization/rounding selection |
| order_m1 | output | 8 | Filter taps minus one |
| coef_we | output | 1 | Coefficient write pulse |
| coef_addr | output | 8 | Coefficient index |
| coef_data | output | 16 | Coefficient value |

## Verification
Register writes take effect on the clock edge where ST_IDLE first sees the access. Read data and coef_we are registered, so each is due one clock after the access begins. Padding writes follow on the next one to three clocks. The bench drives pins on falling edges and samples at the falling edge after the relevant rising edge. Between accesses it leaves at least four idle clocks, so any padding burst has ended before the next check. Coefficient writes are collected by a falling-edge monitor into a bench array. That array is compared with values computed from the bytes sent and the selected byte order.

// File: rtl/host_reg_pkg.sv
package host_reg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR_HOLD,
        ST_RD_HOLD,
        ST_PAD
    } hst_state_e;

    localparam logic [1:0] A_COEF  = 2'd0;
    localparam logic [1:0] A_CFG   = 2'd1;
    localparam logic [1:0] A_NORM  = 2'd2;
    localparam logic [1:0] A_ORDER = 2'd3;

    localparam int CFG_RUN  = 0;
    localparam int CFG_MODE = 1;
    localparam int CFG_MSB  = 2;
    localparam int CFG_LOCK = 3;
endpackage

// File: rtl/host_bus_decode.sv
module host_bus_decode (
    input  logic cs_n,
    input  logic strb_n,
    input  logic rw,
    input  logic split_mode,
    output logic acc_wr,
    output logic acc_rd,
    output logic acc_any
);
    always_comb begin
        if (split_mode) begin
            acc_wr  = !cs_n && !strb_n;
            acc_rd  = !cs_n && !rw && strb_n;
            acc_any = !cs_n && (!strb_n || !rw);
        end else begin
            acc_any = !cs_n && !strb_n;
            acc_wr  = acc_any && !rw;
            acc_rd  = acc_any && rw;
        end
    end
endmodule

// File: rtl/coef_loader.sv
module coef_loader #(
    parameter int DATA_W    = 8,
    parameter int IDX_W     = 8,
    parameter int CELL_LOG2 = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                byte_wr,
    input  logic [DATA_W-1:0]   byte_in,
    input  logic                msb_first,
    input  logic [IDX_W-1:0]    order,
    input  logic                restart,
    input  logic                pad_go,
    output logic                coef_we,
    output logic [IDX_W-1:0]    coef_addr,
    output logic [2*DATA_W-1:0] coef_data,
    output logic                pad_needed,
    output logic                pad_last,
    output logic                at_last,
    output logic                in_last_grp
);
    logic              phase_q;
    logic [DATA_W-1:0] first_q;
    logic [IDX_W-1:0]  cptr_q;
    logic [IDX_W-1:0]  pad_ptr_q;

    assign at_last     = (cptr_q == order);
    assign in_last_grp = (order[IDX_W-1:CELL_LOG2] != '0) &&
                         (cptr_q[IDX_W-1:CELL_LOG2] == order[IDX_W-1:CELL_LOG2]);
    assign pad_needed  = byte_wr && phase_q && at_last &&
                         (order[CELL_LOG2-1:0] != '1);
    assign pad_last    = (pad_ptr_q[CELL_LOG2-1:0] == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q   <= 1'b0;
            first_q   <= '0;
            cptr_q    <= '0;
            pad_ptr_q <= '0;
            coef_we   <= 1'b0;
            coef_addr <= '0;
            coef_data <= '0;
        end else begin
            coef_we <= 1'b0;
            if (restart) begin
                phase_q <= 1'b0;
                cptr_q  <= '0;
            end else if (byte_wr) begin
                if (!phase_q) begin
                    first_q <= byte_in;
                    phase_q <= 1'b1;
                end else begin
                    phase_q   <= 1'b0;
                    coef_we   <= 1'b1;
                    coef_addr <= cptr_q;
                    coef_data <= msb_first ? {first_q, byte_in} : {byte_in, first_q};
                    cptr_q    <= at_last ? '0 : cptr_q + 1'b1;
                    pad_ptr_q <= cptr_q + 1'b1;
                end
            end else if (pad_go) begin
                coef_we   <= 1'b1;
                coef_addr <= pad_ptr_q;
                coef_data <= '0;
                pad_ptr_q <= pad_ptr_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/host_reg_port.sv
module host_reg_port
    import host_reg_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NORM_W    = 5,
    parameter int ORDER_W   = 8,
    parameter int CELL_LOG2 = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic [1:0]          bus_addr,
    input  logic                bus_strb_n,
    input  logic                bus_rw,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                buf_full,
    output logic                run_en,
    output logic                seq_mode,
    output logic [NORM_W-1:0]   norm_sel,
    output logic [ORDER_W-1:0]  order_m1,
    output logic                coef_we,
    output logic [ORDER_W-1:0]  coef_addr,
    output logic [2*DATA_W-1:0] coef_data
);
    localparam int COEF_W = 2 * DATA_W;

    hst_state_e         state_q, state_d;
    logic [3:0]         cfg_q;
    logic [NORM_W-1:0]  norm_q;
    logic [ORDER_W-1:0] order_q;
    logic [DATA_W-1:0]  rdata_q;
    logic [DATA_W-1:0]  rd_mux;

    logic acc_wr, acc_rd, acc_any;
    logic locked, split_mode;
    logic wr_fire, rd_fire;
    logic byte_wr, restart, pad_go;
    logic pad_needed, pad_last, at_last, in_last_grp;
    logic [COEF_W-1:0] ld_data;

    assign locked     = cfg_q[CFG_LOCK];
    assign split_mode = cfg_q[CFG_MODE] && locked;

    host_bus_decode u_dec (
        .cs_n       (cs_n),
        .strb_n     (bus_strb_n),
        .rw         (bus_rw),
        .split_mode (split_mode),
        .acc_wr     (acc_wr),
        .acc_rd     (acc_rd),
        .acc_any    (acc_any)
    );

    assign wr_fire = (state_q == ST_IDLE) && acc_wr;
    assign rd_fire = (state_q == ST_IDLE) && acc_rd && !acc_wr;
    assign byte_wr = wr_fire && locked && (bus_addr == A_COEF);
    assign restart = wr_fire && locked && (bus_addr == A_ORDER);
    assign pad_go  = (state_q == ST_PAD);

    coef_loader #(
        .DATA_W    (DATA_W),
        .IDX_W     (ORDER_W),
        .CELL_LOG2 (CELL_LOG2)
    ) u_ld (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_wr     (byte_wr),
        .byte_in     (bus_wdata),
        .msb_first   (cfg_q[CFG_MSB]),
        .order       (order_q),
        .restart     (restart),
        .pad_go      (pad_go),
        .coef_we     (coef_we),
        .coef_addr   (coef_addr),
        .coef_data   (ld_data),
        .pad_needed  (pad_needed),
        .pad_last    (pad_last),
        .at_last     (at_last),
        .in_last_grp (in_last_grp)
    );
    assign coef_data = ld_data;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_fire)      state_d = pad_needed ? ST_PAD : ST_WR_HOLD;
                else if (rd_fire) state_d = ST_RD_HOLD;
            end
            ST_WR_HOLD: if (!acc_any) state_d = ST_IDLE;
            ST_RD_HOLD: if (!acc_any) state_d = ST_IDLE;
            ST_PAD:     if (pad_last) state_d = ST_WR_HOLD;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign seq_mode = (order_q[ORDER_W-1:CELL_LOG2] != '0);

    always_comb begin
        unique case (bus_addr)
            A_CFG:   rd_mux = DATA_W'({at_last, in_last_grp, buf_full, seq_mode, cfg_q});
            A_NORM:  rd_mux = DATA_W'(norm_q);
            A_ORDER: rd_mux = DATA_W'(order_q);
            default: rd_mux = '0;
        endcase
    end

    // registers and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= 4'b0010;
            norm_q  <= '0;
            order_q <= '0;
            rdata_q <= '0;
        end else begin
            if (wr_fire) begin
                unique case (bus_addr)
                    A_CFG: begin
                        if (locked) begin
                            cfg_q[CFG_RUN] <= bus_wdata[CFG_RUN];
                            cfg_q[CFG_MSB] <= bus_wdata[CFG_MSB];
                        end else begin
                            cfg_q <= bus_wdata[3:0];
                        end
                    end
                    A_NORM:  if (locked) norm_q  <= bus_wdata[NORM_W-1:0];
                    A_ORDER: if (locked) order_q <= bus_wdata[ORDER_W-1:0];
                    default: ;
                endcase
            end
            if (rd_fire)
                rdata_q <= rd_mux;
            else if (!((state_q == ST_RD_HOLD) && acc_any))
                rdata_q <= '0;
        end
    end

    assign bus_rdata = rdata_q;
    assign run_en    = cfg_q[CFG_RUN] && locked;
    assign norm_sel  = norm_q;
    assign order_m1  = order_q;
endmodule

// File: rtl/host_reg_port_chk.sv
module host_reg_port_chk #(
    parameter int DATA_W  = 8,
    parameter int ORDER_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lock_q,
    input logic                mode_q,
    input logic                run_en,
    input logic                coef_we,
    input logic [ORDER_W-1:0]  coef_addr,
    input logic [2*DATA_W-1:0] coef_data,
    input logic [ORDER_W-1:0]  order_m1
);
    p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    p_mode_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(mode_q));

    p_run_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |-> lock_q);

    p_no_coef_unlocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_q |-> !coef_we);

    p_order_held_unlocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_q |=> $stable(order_m1));

    p_pad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_we && (coef_addr > order_m1)) |-> (coef_data == '0));
endmodule

bind host_reg_port host_reg_port_chk #(
    .DATA_W  (DATA_W),
    .ORDER_W (ORDER_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_q    (cfg_q[3]),
    .mode_q    (cfg_q[1]),
    .run_en    (run_en),
    .coef_we   (coef_we),
    .coef_addr (coef_addr),
    .coef_data (coef_data),
    .order_m1  (order_m1)
);

// File: tb/host_reg_port_tb.sv
module host_reg_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_strb_n = 1'b1;
    logic        bus_rw = 1'b1;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic        buf_full = 1'b1;
    logic        run_en, seq_mode, coef_we;
    logic [4:0]  norm_sel;
    logic [7:0]  order_m1, coef_addr;
    logic [15:0] coef_data;

    int n_chk = 0;
    int n_bad = 0;
    bit split = 1'b0;
    bit done = 1'b0;

    logic [15:0] cmem [256];
    logic [15:0] emem [256];
    int cwrites = 0;

    always #10 clk = ~clk;

    host_reg_port u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bus_addr(bus_addr),
        .bus_strb_n(bus_strb_n), .bus_rw(bus_rw), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .buf_full(buf_full), .run_en(run_en),
        .seq_mode(seq_mode), .norm_sel(norm_sel), .order_m1(order_m1),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data)
    );

    always @(negedge clk) begin
        if (coef_we) begin
            cmem[coef_addr] = coef_data;
            cwrites++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pair(input logic [7:0] b0, input logic [7:0] b1, input bit msb);
        return msb ? {b0, b1} : {b1, b0};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; bus_addr = a; bus_wdata = d;
        bus_strb_n = 1'b0;
        bus_rw = split ? 1'b1 : 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1; bus_strb_n = 1'b1; bus_rw = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; bus_addr = a;
        if (split) begin bus_strb_n = 1'b1; bus_rw = 1'b0; end
        else       begin bus_strb_n = 1'b0; bus_rw = 1'b1; end
        @(negedge clk);
        d = bus_rdata;
        @(negedge clk);
        chk("R2 read data held", bus_rdata, d);
        cs_n = 1'b1; bus_strb_n = 1'b1; bus_rw = 1'b1;
        @(negedge clk);
        chk("R2 read data cleared", bus_rdata, 8'h00);
        repeat (2) @(negedge clk);
    endtask

    task automatic rchk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cs_n = 1'b1; bus_strb_n = 1'b1; bus_rw = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic load(input int ntaps, input bit msb);
        for (int k = 0; k < 256; k++) begin cmem[k] = 16'hFFFF; emem[k] = 16'hFFFF; end
        cwrites = 0;
        for (int k = 0; k < ntaps; k++) begin
            logic [7:0] b0, b1;
            b0 = 8'($urandom);
            b1 = 8'($urandom);
            emem[k] = pair(b0, b1, msb);
            wr(2'd0, b0);
            wr(2'd0, b1);
        end
        for (int k = ntaps; (k % 4) != 0; k++) emem[k] = 16'h0000;
    endtask

    task automatic cmp_mem(input string tag, input int upto);
        for (int k = 0; k < upto; k++) chk(tag, cmem[k], emem[k]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] nb;
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset state
        rchk("R1 cfg reset", 2'd1, 8'hA2);
        rchk("R1 norm reset", 2'd2, 8'h00);
        rchk("R1 order reset", 2'd3, 8'h00);
        chk("R1 run_en reset", run_en, 1'b0);
        chk("R1 seq_mode reset", seq_mode, 1'b0);

        // R3 unlocked writes ignored
        wr(2'd3, 8'h10);
        wr(2'd2, 8'h1F);
        wr(2'd0, 8'h55);
        wr(2'd0, 8'hAA);
        chk("R3 no coef write unlocked", cwrites, 0);
        rchk("R3 order unchanged", 2'd3, 8'h00);
        rchk("R3 norm unchanged", 2'd2, 8'h00);
        rchk("R10 addr0 reads zero", 2'd0, 8'h00);

        // R2/R6 lock in strobe/direction style, MSB first
        wr(2'd1, 8'h0C);
        rchk("R6 cfg after lock", 2'd1, 8'hAC);
        // R5 lock sticky, mode frozen
        wr(2'd1, 8'h00);
        rchk("R5 lock kept", 2'd1, 8'hA8);
        wr(2'd1, 8'h07);
        rchk("R5 bits 0/2 writable, bit1 frozen", 2'd1, 8'hAD);
        chk("R11 run_en set", run_en, 1'b1);
        wr(2'd1, 8'h04);
        chk("R11 run_en cleared", run_en, 1'b0);
        wr(2'd1, 8'hFC);
        rchk("R6 status bits ignore writes", 2'd1, 8'hAC);

        // R7 norm/order
        wr(2'd3, 8'h05);
        rchk("R7 order readback", 2'd3, 8'h05);
        chk("R7 order_m1 pin", order_m1, 8'h05);
        wr(2'd2, 8'hFF);
        rchk("R7 norm readback", 2'd2, 8'h1F);
        chk("R7 norm_sel pin", norm_sel, 5'h1F);
        chk("R6 seq_mode", seq_mode, 1'b1);
        buf_full = 1'b0;
        rchk("R6 cfg order5 idx0", 2'd1, 8'h1C);
        buf_full = 1'b1;

        // R8/R9 six taps, MSB first
        load(4, 1'b1);
        rchk("R6 last group flag", 2'd1, 8'h7C);
        begin
            logic [7:0] b0, b1;
            b0 = 8'($urandom); b1 = 8'($urandom);
            emem[4] = pair(b0, b1, 1'b1);
            wr(2'd0, b0); wr(2'd0, b1);
        end
        rchk("R6 last coef flag", 2'd1, 8'hFC);
        begin
            logic [7:0] b0, b1;
            b0 = 8'($urandom); b1 = 8'($urandom);
            emem[5] = pair(b0, b1, 1'b1);
            wr(2'd0, b0); wr(2'd0, b1);
        end
        emem[6] = 16'h0000; emem[7] = 16'h0000;
        cmp_mem("R8 msb-first coef", 6);
        chk("R9 pad idx6", cmem[6], 16'h0000);
        chk("R9 pad idx7", cmem[7], 16'h0000);
        chk("R9 write count", cwrites, 8);
        rchk("R9 index wrapped", 2'd1, 8'h3C);

        // R7 restart mid-pair, R8 LSB first, R9 pad one
        wr(2'd1, 8'h08);
        wr(2'd0, 8'hEE);
        wr(2'd3, 8'h02);
        load(3, 1'b0);
        cmp_mem("R8 lsb-first coef", 4);
        chk("R9 single pad count", cwrites, 4);

        // order 0 pads three
        wr(2'd3, 8'h00);
        chk("R6 seq_mode off", seq_mode, 1'b0);
        load(1, 1'b0);
        cmp_mem("R9 order0 pad", 4);
        chk("R9 order0 count", cwrites, 4);

        // R4 split-strobe style after fresh reset
        do_reset();
        chk("R5 reset clears lock", run_en, 1'b0);
        wr(2'd1, 8'h0A);
        split = 1'b1;
        buf_full = 1'b0;
        rchk("R4 split read cfg", 2'd1, 8'h8A);
        nb = 8'($urandom) & 8'h1F;
        wr(2'd2, nb);
        rchk("R4 split norm", 2'd2, nb);
        wr(2'd1, 8'h0B);
        chk("R11 run_en split", run_en, 1'b1);
        wr(2'd3, 8'h81);
        rchk("R4 split order", 2'd3, 8'h81);
        load(130, 1'b0);
        cmp_mem("R8 long load", 132);
        chk("R9 long count", cwrites, 132);
        rd(2'd0, v);
        chk("R10 addr0 split", v, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule